// File: doc/BRIEF.md
# Bit-Slice Ripple ALU with Signed Less-Than

This block is a parameterised integer ALU built as a chain of one-bit slices. Each slice computes the AND, the OR and the full-adder sum of its operand bits. Carries ripple from the least significant slice to the most significant one. A three-bit function code selects which value each slice passes out. The top bit of the code is a single negate line. It inverts `b` in every slice and also forms the carry into slice 0, so subtraction and comparison reuse the adder.

For the signed less-than operation, the most significant slice computes a "set" value: the sign of `a - b` corrected by the overflow of that difference. This value is routed back to the less input of slice 0. Every other slice receives a constant 0 on its less input. Overflow detection lives only in the most significant slice. The combinational result and its flags are captured in output registers, so every answer appears one clock after its operands are presented.

Top module: `ripple_alu`

## Requirements
- R1: Code 3'b000 gives `res_q = op_a & op_b` and code 3'b001 gives `res_q = op_a | op_b`, both visible on the rising edge after the inputs are sampled.
- R2: Code 3'b010 gives `res_q = (op_a + op_b) mod 2^WIDTH`, with `cout_q` equal to the carry out of the top bit.
- R3: Code 3'b110 gives `res_q = (op_a - op_b) mod 2^WIDTH`, with `cout_q` equal to the carry out of the top bit of `op_a + ~op_b + 1` (1 exactly when `op_a >= op_b` unsigned).
- R4: Code 3'b111 sets bit 0 of `res_q` to 1 when `op_a < op_b` as two's-complement signed numbers and clears every other bit. The result stays correct when `op_a - op_b` overflows.
- R5: For codes 3'b010 and 3'b110, `ovf_q` flags signed overflow of the sum or difference. For every other code, `ovf_q` and `cout_q` are 0.
- R6: `zero_q` is 1 exactly when all bits of `res_q` are 0 (outside reset).
- R7: The unused codes 3'b011, 3'b100 and 3'b101 give `res_q = 0`, `zero_q = 1`, `ovf_q = 0` and `cout_q = 0`.
- R8: While `rst` is high at a rising edge, all four outputs are cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_code | input | 3 | Function code; bit 2 is the negate line |
| res_q | output | WIDTH | Registered result |
| zero_q | output | 1 | Registered all-zero flag of the result |
| ovf_q | output | 1 | Registered signed-overflow flag (add and subtract only) |
| cout_q | output | 1 | Registered carry out of the top slice (add and subtract only) |

## Verification
The bench builds the block at its default WIDTH of 32. At that width, the sign boundaries 32'h7FFFFFFF and 32'h80000000 are reachable. Pairing them with 0, 1 and all-ones drives every overflow case of add, subtract and the overflow-corrected less-than. Random operands at full width exercise long carry ripples through all 32 slices. Every code, including the three unused ones, is applied against a reference model computed with wider integer arithmetic.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;

  localparam int CODE_W = 3;

  localparam logic [CODE_W-1:0] CODE_AND = 3'b000;
  localparam logic [CODE_W-1:0] CODE_OR  = 3'b001;
  localparam logic [CODE_W-1:0] CODE_ADD = 3'b010;
  localparam logic [CODE_W-1:0] CODE_SUB = 3'b110;
  localparam logic [CODE_W-1:0] CODE_SLT = 3'b111;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_SUM  = 2'b10,
    FN_LESS = 2'b11
  } slice_fn_t;

endpackage

// File: rtl/alu_code_decode.sv
module alu_code_decode
  import ripple_alu_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic              negate,
  output slice_fn_t         fn,
  output logic              known,
  output logic              arith
);

  always_comb begin
    negate = code[2];
    fn     = slice_fn_t'(code[1:0]);
    known  = 1'b0;
    arith  = 1'b0;
    unique case (code)
      CODE_AND, CODE_OR, CODE_SLT: known = 1'b1;
      CODE_ADD, CODE_SUB: begin
        known = 1'b1;
        arith = 1'b1;
      end
      default: known = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import ripple_alu_pkg::*;
(
  input  logic      a,
  input  logic      b,
  input  logic      cin,
  input  logic      negate,
  input  logic      less,
  input  slice_fn_t fn,
  output logic      res,
  output logic      cout
);

  logic bx;
  logic sum;

  assign bx   = b ^ negate;
  assign sum  = a ^ bx ^ cin;
  assign cout = (a & bx) | (a & cin) | (bx & cin);

  always_comb begin
    unique case (fn)
      FN_AND:  res = a & bx;
      FN_OR:   res = a | bx;
      FN_SUM:  res = sum;
      FN_LESS: res = less;
      default: res = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_top_slice.sv
module alu_top_slice
  import ripple_alu_pkg::*;
(
  input  logic      a,
  input  logic      b,
  input  logic      cin,
  input  logic      negate,
  input  logic      less,
  input  slice_fn_t fn,
  output logic      res,
  output logic      cout,
  output logic      set,
  output logic      ovf
);

  logic bx;
  logic sum;
  logic carry;

  assign bx    = b ^ negate;
  assign sum   = a ^ bx ^ cin;
  assign carry = (a & bx) | (a & cin) | (bx & cin);
  assign cout  = carry;
  // signed overflow: carry entering the sign bit differs from carry leaving it
  assign ovf   = cin ^ carry;
  // sign of the difference, corrected when the difference overflowed
  assign set   = sum ^ (cin ^ carry);

  always_comb begin
    unique case (fn)
      FN_AND:  res = a & bx;
      FN_OR:   res = a | bx;
      FN_SUM:  res = sum;
      FN_LESS: res = less;
      default: res = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
  import ripple_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             negate,
  input  slice_fn_t        fn,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] carry;
  logic           set_fb;

  // the negate line doubles as the carry into slice 0
  assign carry[0] = negate;
  assign cout     = carry[WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == MSB) begin : g_top
      alu_top_slice u_top (
        .a      (a[i]),
        .b      (b[i]),
        .cin    (carry[i]),
        .negate (negate),
        .less   ((i == 0) ? set_fb : 1'b0),
        .fn     (fn),
        .res    (res[i]),
        .cout   (carry[i+1]),
        .set    (set_fb),
        .ovf    (ovf)
      );
    end else begin : g_low
      alu_bit_slice u_bit (
        .a      (a[i]),
        .b      (b[i]),
        .cin    (carry[i]),
        .negate (negate),
        .less   ((i == 0) ? set_fb : 1'b0),
        .fn     (fn),
        .res    (res[i]),
        .cout   (carry[i+1])
      );
    end
  end

endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import ripple_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  input  logic [CODE_W-1:0] op_code,
  output logic [WIDTH-1:0]  res_q,
  output logic              zero_q,
  output logic              ovf_q,
  output logic              cout_q
);

  logic             negate;
  slice_fn_t        fn;
  logic             known;
  logic             arith;
  logic [WIDTH-1:0] chain_res;
  logic             chain_cout;
  logic             chain_ovf;
  logic [WIDTH-1:0] res_d;

  alu_code_decode u_dec (
    .code   (op_code),
    .negate (negate),
    .fn     (fn),
    .known  (known),
    .arith  (arith)
  );

  alu_slice_chain #(.WIDTH(WIDTH)) u_chain (
    .a      (op_a),
    .b      (op_b),
    .negate (negate),
    .fn     (fn),
    .res    (chain_res),
    .cout   (chain_cout),
    .ovf    (chain_ovf)
  );

  assign res_d = known ? chain_res : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      zero_q <= 1'b0;
      ovf_q  <= 1'b0;
      cout_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      zero_q <= ~|res_d;
      ovf_q  <= arith & chain_ovf;
      cout_q <= arith & chain_cout;
    end
  end

endmodule

// File: rtl/ripple_alu_checker.sv
module ripple_alu_checker
  import ripple_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [WIDTH-1:0]  op_a,
  input logic [WIDTH-1:0]  op_b,
  input logic [CODE_W-1:0] op_code,
  input logic [WIDTH-1:0]  res_q,
  input logic              zero_q,
  input logic              ovf_q,
  input logic              cout_q
);

  logic [WIDTH-1:0]  pa, pb;
  logic [CODE_W-1:0] pc;
  logic              p_ok;
  logic              p_rst;
  logic [WIDTH:0]    ref_add;
  logic [WIDTH:0]    ref_sub;

  always_ff @(posedge clk) begin
    pa    <= op_a;
    pb    <= op_b;
    pc    <= op_code;
    p_ok  <= !rst;
    p_rst <= rst;
  end

  assign ref_add = {1'b0, pa} + {1'b0, pb};
  assign ref_sub = {1'b0, pa} + {1'b0, ~pb} + {{WIDTH{1'b0}}, 1'b1};

  a_r1_and: assert property (@(posedge clk) disable iff (rst)
    (p_ok && pc == CODE_AND) |-> res_q == (pa & pb));

  a_r1_or: assert property (@(posedge clk) disable iff (rst)
    (p_ok && pc == CODE_OR) |-> res_q == (pa | pb));

  a_r2_add: assert property (@(posedge clk) disable iff (rst)
    (p_ok && pc == CODE_ADD) |-> (res_q == ref_add[WIDTH-1:0] && cout_q == ref_add[WIDTH]));

  a_r3_sub: assert property (@(posedge clk) disable iff (rst)
    (p_ok && pc == CODE_SUB) |-> (res_q == ref_sub[WIDTH-1:0] && cout_q == ref_sub[WIDTH]));

  a_r4_less: assert property (@(posedge clk) disable iff (rst)
    (p_ok && pc == CODE_SLT) |->
      res_q == {{(WIDTH-1){1'b0}}, ($signed(pa) < $signed(pb))});

  a_r5_add_overflow: assert property (@(posedge clk) disable iff (rst)
    (p_ok && pc == CODE_ADD) |->
      ovf_q == ((pa[WIDTH-1] == pb[WIDTH-1]) && (res_q[WIDTH-1] != pa[WIDTH-1])));

  a_r5_flags_idle: assert property (@(posedge clk) disable iff (rst)
    (p_ok && pc != CODE_ADD && pc != CODE_SUB) |-> (!ovf_q && !cout_q));

  a_r6_zero: assert property (@(posedge clk) disable iff (rst)
    p_ok |-> zero_q == (res_q == '0));

  a_r7_unused: assert property (@(posedge clk) disable iff (rst)
    (p_ok && (pc == 3'b011 || pc == 3'b100 || pc == 3'b101)) |-> res_q == '0);

  a_r8_reset: assert property (@(posedge clk)
    p_rst |-> (res_q == '0 && !zero_q && !ovf_q && !cout_q));

endmodule

bind ripple_alu ripple_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_a    (op_a),
  .op_b    (op_b),
  .op_code (op_code),
  .res_q   (res_q),
  .zero_q  (zero_q),
  .ovf_q   (ovf_q),
  .cout_q  (cout_q)
);

// File: tb/ripple_alu_test.sv
`timescale 1ns/1ps
module ripple_alu_test;

  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         zero;
    logic         ovf;
    logic         cout;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [2:0]   op_code = 3'b000;
  logic [W-1:0] res_q;
  logic         zero_q, ovf_q, cout_q;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  ripple_alu #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_code(op_code),
    .res_q(res_q), .zero_q(zero_q), .ovf_q(ovf_q), .cout_q(cout_q)
  );

  function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic [2:0] c);
    exp_t        e;
    logic [W:0]  s;
    e.res = '0; e.ovf = 1'b0; e.cout = 1'b0;
    case (c)
      3'b000: begin e.res = a & b; e.tag = "R1"; end
      3'b001: begin e.res = a | b; e.tag = "R1"; end
      3'b010: begin
        s = {1'b0, a} + {1'b0, b};
        e.res = s[W-1:0]; e.cout = s[W];
        e.ovf = (a[W-1] == b[W-1]) && (e.res[W-1] != a[W-1]);
        e.tag = "R2/R5";
      end
      3'b110: begin
        s = {1'b0, a} + {1'b0, ~b} + 1;
        e.res = s[W-1:0]; e.cout = s[W];
        e.ovf = (a[W-1] != b[W-1]) && (e.res[W-1] != a[W-1]);
        e.tag = "R3/R5";
      end
      3'b111: begin
        e.res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
        e.tag = "R4";
      end
      default: e.tag = "R7";
    endcase
    e.zero = (e.res == '0);
    return e;
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] c);
    @(negedge clk);
    op_a = a; op_b = b; op_code = c;
    sb.push_back(model(a, b, c));
  endtask

  task automatic pulse_reset();
    exp_t e;
    @(negedge clk);
    rst = 1'b1;
    e.res = '0; e.zero = 1'b0; e.ovf = 1'b0; e.cout = 1'b0; e.tag = "R8";
    sb.push_back(e);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor: compares one result per edge, after the registers settle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (res_q !== e.res || zero_q !== e.zero || ovf_q !== e.ovf || cout_q !== e.cout) begin
          errors++;
          $display("FAIL %s: res=%h zero=%b ovf=%b cout=%b expected res=%h zero=%b ovf=%b cout=%b",
                   e.tag, res_q, zero_q, ovf_q, cout_q, e.res, e.zero, e.ovf, e.cout);
        end
      end
    end
  end

  logic [W-1:0] corner [5];
  logic [2:0]   codes  [8];

  initial begin
    corner[0] = '0;
    corner[1] = {{(W-1){1'b0}}, 1'b1};
    corner[2] = '1;
    corner[3] = {1'b0, {(W-1){1'b1}}};
    corner[4] = {1'b1, {(W-1){1'b0}}};
    for (int k = 0; k < 8; k++) codes[k] = k[2:0];

    // R8: outputs held at zero during the initial reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (res_q !== '0 || zero_q !== 1'b0 || ovf_q !== 1'b0 || cout_q !== 1'b0) begin
      errors++;
      $display("FAIL R8: res=%h zero=%b ovf=%b cout=%b expected all zero",
               res_q, zero_q, ovf_q, cout_q);
    end
    rst = 1'b0;

    // corner operands with every code, used codes and unused ones (R7)
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int k = 0; k < 8; k++)
          apply(corner[i], corner[j], codes[k]);

    // R4: less-than where the difference overflows
    apply(32'h7FFF_FFFF, 32'h8000_0000, 3'b111);
    apply(32'h8000_0000, 32'h0000_0001, 3'b111);
    // R6: results that are exactly zero
    apply(32'h1234_5678, 32'h1234_5678, 3'b110);
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);
    apply(32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'b000);

    // R8: reset in mid-stream clears the outputs
    apply(32'hDEAD_BEEF, 32'h0000_0011, 3'b001);
    pulse_reset();

    // random operands with every code
    for (int n = 0; n < 400; n++)
      apply($urandom, $urandom, codes[n % 8]);

    // R4 with nearby operands, both signs
    for (int n = 0; n < 100; n++) begin
      logic [W-1:0] x;
      x = $urandom;
      apply(x, x + {{(W-4){1'b0}}, 4'(n % 3)}, 3'b111);
      apply(x + {{(W-4){1'b0}}, 4'(n % 3)}, x, 3'b111);
    end

    @(negedge clk);
    op_code = 3'b000;
    repeat (4) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule